// File: doc/BRIEF.md
# Interrupt Priority Tracking Controller

This block keeps track of interrupt vectors for one processor: which vectors are waiting, which are being serviced, and whether each waiting or serviced vector was raised as level or edge. A task priority value written by software sets a floor below which nothing is delivered. The block combines that floor with the class of the highest vector in service to form a processor priority. It offers the highest waiting vector only when that vector's priority class clears the processor priority.

Sources present vectors on an accept port. The port has no back-pressure: a presented vector is either taken or dropped in the same cycle, and `acc_ok` reports which. The processor side sees the offer as a valid/ready pair. `intr_valid` with `intr_vector` is the offer and `intr_ack` acts as ready. The vector moves into service only on a cycle where both are high. An offer may disappear without an acknowledge, for example when the task priority is raised, and an acknowledge without a valid offer has no effect. An end-of-interrupt strobe retires the highest vector in service. One cycle later the block reports the retired vector and its trigger mode so that an upstream router can re-arm level sources.

Top module: `ipt_ctrl`

## Requirements
- R1: After reset nothing is waiting or in service, the task priority is 0, `ppr_out` is 0, `intr_valid` is 0 and `eoi_valid` is 0.
- R2: An accept (`acc_valid`, `en` high) of a vector that is not waiting makes it waiting and drives `acc_ok` high in that cycle. An accept of a vector that is already waiting is dropped with `acc_ok` low. `acc_level` = 1 records level mode and 0 records edge mode for that vector.
- R3: While `en` is low, accepts are dropped (`acc_ok` low) and `intr_valid` is low.
- R4: `intr_valid` is high exactly when `en` is high, some vector is waiting, and (highest waiting vector AND 0xF0) is strictly greater than the current processor priority. `intr_vector` is then the highest waiting vector number (vector v is bit v of the bitmap, word v[7:5], bit v[4:0]).
- R5: The processor priority is the full task priority when task[7:4] >= S[7:4], and S AND 0xF0 otherwise. S is the highest vector in service, or 0 when none is. `ppr_out` shows this value one clock after the state it is derived from.
- R6: On a cycle with `intr_valid` and `intr_ack` both high, the offered vector stops waiting and enters service. Waiting vectors of the same or a lower class are then withheld.
- R7: An `eoi_req` while something is in service removes the highest vector in service and clears its trigger record. On the next cycle `eoi_valid` pulses for one cycle, with `eoi_vector` set to that vector and `eoi_level` set to 1 for level or 0 for edge.
- R8: An `eoi_req` with nothing in service changes nothing and produces no `eoi_valid` pulse.
- R9: If an accept names the vector being acknowledged in the same cycle, the acknowledge is applied first and the accept is then taken (`acc_ok` high). The vector is both in service and waiting afterwards.
- R10: `intr_ack` while `intr_valid` is low changes no waiting or in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; gates accepts and offers |
| acc_valid | input | 1 | Accept request |
| acc_vector | input | 8 | Vector to accept |
| acc_level | input | 1 | 1 = level, 0 = edge |
| acc_ok | output | 1 | Accept taken this cycle |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_data | input | 8 | New task priority |
| intr_valid | output | 1 | A vector is offered |
| intr_vector | output | 8 | Offered vector |
| intr_ack | input | 1 | Processor takes the offered vector |
| eoi_req | input | 1 | End-of-interrupt strobe |
| eoi_valid | output | 1 | One-cycle retirement report |
| eoi_vector | output | 8 | Retired vector |
| eoi_level | output | 1 | Retired vector was level-triggered |
| ppr_out | output | 8 | Registered processor priority |

## Verification
The bench targets the class boundary. A vector in the same class as the one in service must be withheld, so a design that compares full vectors instead of classes would deliver it. A design that used `>=` instead of `>` would wrongly offer a vector whose class equals a task priority class. The bench retires a level vector and an edge vector in turn, so a design that reads the trigger record after clearing it would report every retirement as edge. It also drives an accept and an acknowledge of the same vector in one cycle, where applying them in the wrong order would lose the new request. Random traffic with many duplicate vectors and occasional priority writes covers the remaining interleavings.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  // Low bits of a vector that lie below its priority class.
  localparam int CLASS_LSB = 4;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/ipt_prio_enc.sv
// Highest-set-bit finder over a bitmap held as words of W bits.
module ipt_prio_enc #(
  parameter int N = 256,
  parameter int W = 32
) (
  input  logic [N-1:0]         bits,
  output logic                 found,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW  = $clog2(N);
  localparam int NW  = N / W;
  localparam int WIW = (W > 1) ? $clog2(W) : 1;

  logic [NW-1:0]          wany;
  logic [NW-1:0][WIW-1:0] widx;

  generate
    for (genvar g = 0; g < NW; g++) begin : g_word
      logic [WIW-1:0] hi;
      always_comb begin
        hi = '0;
        for (int b = 0; b < W; b++) begin
          if (bits[g*W + b]) hi = WIW'(b);
        end
      end
      assign wany[g] = |bits[g*W +: W];
      assign widx[g] = hi;
    end
  endgenerate

  // Later (higher) words override earlier ones: top word wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int w = 0; w < NW; w++) begin
      if (wany[w]) begin
        found = 1'b1;
        idx   = IW'(w * W) + IW'(widx[w]);
      end
    end
  end
endmodule

// File: rtl/ipt_prio_calc.sv
// Processor priority from task priority and top in-service vector.
module ipt_prio_calc
  import ipt_pkg::*;
#(
  parameter int VW = 8
) (
  input  logic [VW-1:0] tpr,
  input  logic          isr_found,
  input  logic [VW-1:0] isr_top,
  output logic [VW-1:0] ppr
);
  logic [VW-1:0] srv;

  always_comb begin
    srv = isr_found ? isr_top : '0;
    if (tpr[VW-1:CLASS_LSB] >= srv[VW-1:CLASS_LSB]) ppr = tpr;
    else ppr = {srv[VW-1:CLASS_LSB], {CLASS_LSB{1'b0}}};
  end
endmodule

// File: rtl/ipt_ctrl.sv
module ipt_ctrl
  import ipt_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       acc_valid,
  input  logic [$clog2(NUM_VEC)-1:0] acc_vector,
  input  logic                       acc_level,
  output logic                       acc_ok,
  input  logic                       tpr_wr,
  input  logic [$clog2(NUM_VEC)-1:0] tpr_data,
  output logic                       intr_valid,
  output logic [$clog2(NUM_VEC)-1:0] intr_vector,
  input  logic                       intr_ack,
  input  logic                       eoi_req,
  output logic                       eoi_valid,
  output logic [$clog2(NUM_VEC)-1:0] eoi_vector,
  output logic                       eoi_level,
  output logic [$clog2(NUM_VEC)-1:0] ppr_out
);
  localparam int VW = $clog2(NUM_VEC);

  logic [NUM_VEC-1:0] pend_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] pend_n, isr_n, tmr_n;
  logic [VW-1:0]      tpr_q, ppr_q, ppr_now;
  logic               pend_found, isr_found;
  logic [VW-1:0]      pend_top, isr_top;
  logic [VW-1:0]      pend_floor;
  logic               ack_fire, eoi_fire, same_vec;
  trig_e              acc_trig;

  ipt_prio_enc #(.N(NUM_VEC), .W(WORD_W)) u_pend_enc (
    .bits(pend_q), .found(pend_found), .idx(pend_top));

  ipt_prio_enc #(.N(NUM_VEC), .W(WORD_W)) u_isr_enc (
    .bits(isr_q), .found(isr_found), .idx(isr_top));

  ipt_prio_calc #(.VW(VW)) u_ppr (
    .tpr(tpr_q), .isr_found(isr_found), .isr_top(isr_top), .ppr(ppr_now));

  // Offer: class of the highest waiting vector must beat current priority.
  assign pend_floor  = {pend_top[VW-1:CLASS_LSB], {CLASS_LSB{1'b0}}};
  assign intr_valid  = en && pend_found && (pend_floor > ppr_now);
  assign intr_vector = pend_top;

  assign ack_fire = intr_valid && intr_ack;
  assign eoi_fire = eoi_req && isr_found;
  assign same_vec = ack_fire && (intr_vector == acc_vector);
  assign acc_ok   = acc_valid && en && (!pend_q[acc_vector] || same_vec);
  assign acc_trig = acc_level ? TRIG_LEVEL : TRIG_EDGE;

  // Order inside a cycle: acknowledge, retirement, then accept.
  always_comb begin
    pend_n = pend_q;
    isr_n  = isr_q;
    tmr_n  = tmr_q;
    if (ack_fire) begin
      pend_n[intr_vector] = 1'b0;
      isr_n[intr_vector]  = 1'b1;
    end
    if (eoi_fire) begin
      isr_n[isr_top] = 1'b0;
      tmr_n[isr_top] = 1'b0;
    end
    if (acc_ok) begin
      pend_n[acc_vector] = 1'b1;
      tmr_n[acc_vector]  = (acc_trig == TRIG_LEVEL);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      isr_q      <= '0;
      tmr_q      <= '0;
      tpr_q      <= '0;
      ppr_q      <= '0;
      eoi_valid  <= 1'b0;
      eoi_vector <= '0;
      eoi_level  <= 1'b0;
    end else begin
      pend_q    <= pend_n;
      isr_q     <= isr_n;
      tmr_q     <= tmr_n;
      ppr_q     <= ppr_now;
      eoi_valid <= eoi_fire;
      if (tpr_wr) tpr_q <= tpr_data;
      if (eoi_fire) begin
        eoi_vector <= isr_top;
        eoi_level  <= tmr_q[isr_top];
      end
    end
  end

  assign ppr_out = ppr_q;

  // ---------------- assertions ----------------
  assert_acc_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> pend_q[$past(acc_vector)]);

  assert_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!acc_ok && !intr_valid));

  assert_offer_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
    intr_valid |-> (intr_vector[VW-1:CLASS_LSB] > ppr_now[VW-1:CLASS_LSB]));

  assert_ppr_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ppr_out >= $past(tpr_q));

  assert_ack_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> isr_q[$past(intr_vector)]);

  assert_eoi_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> $past(eoi_req));

  assert_eoi_gone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> !isr_q[eoi_vector]);

  assert_eoi_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_req && (isr_q == '0)) |=> !eoi_valid);

  assert_same_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && en && ack_fire && (acc_vector == intr_vector))
      |=> (pend_q[$past(acc_vector)] && isr_q[$past(acc_vector)]));

  assert_ack_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_ack && !intr_valid && !acc_valid) |=> $stable(pend_q));
endmodule

// File: tb/tb_ipt_ctrl.sv
module tb_ipt_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, acc_valid = 1'b0, acc_level = 1'b0;
  logic [7:0] acc_vector = '0, tpr_data = '0;
  logic       tpr_wr = 1'b0, intr_ack = 1'b0, eoi_req = 1'b0;
  logic       acc_ok, intr_valid, eoi_valid, eoi_level;
  logic [7:0] intr_vector, eoi_vector, ppr_out;

  always #5 clk = ~clk;

  ipt_ctrl dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .acc_valid(acc_valid), .acc_vector(acc_vector), .acc_level(acc_level),
    .acc_ok(acc_ok), .tpr_wr(tpr_wr), .tpr_data(tpr_data),
    .intr_valid(intr_valid), .intr_vector(intr_vector), .intr_ack(intr_ack),
    .eoi_req(eoi_req), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .eoi_level(eoi_level), .ppr_out(ppr_out));

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // Reference state
  bit [255:0] mpend = '0, misr = '0, mtmr = '0;
  bit [7:0]   mtpr = '0, m_ppr = '0, m_evec = '0;
  bit         m_ev = 0, m_elvl = 0;

  function automatic int highest(bit [255:0] b);
    for (int i = 255; i >= 0; i--) if (b[i]) return i;
    return -1;
  endfunction

  function automatic bit [7:0] calc_ppr(bit [7:0] t, bit [255:0] s);
    int h;
    bit [7:0] v;
    h = highest(s);
    v = (h < 0) ? 8'h00 : 8'(h);
    if (t[7:4] >= v[7:4]) return t;
    return {v[7:4], 4'h0};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit av, bit [7:0] avec, bit alvl, bit ack, bit eoi,
                      bit tw, bit [7:0] td, bit e, string tag);
    int hp, ih;
    bit [7:0] hv, pp;
    bit exp_off, afire, efire, exp_acc;
    acc_valid = av; acc_vector = avec; acc_level = alvl;
    intr_ack = ack; eoi_req = eoi; tpr_wr = tw; tpr_data = td; en = e;
    #1;
    hp = highest(mpend);
    hv = (hp < 0) ? 8'h00 : 8'(hp);
    pp = calc_ppr(mtpr, misr);
    exp_off = e && (hp >= 0) && ({hv[7:4], 4'h0} > pp);
    chk(intr_valid == exp_off, "R4", {tag, " offer valid"}, int'(intr_valid), int'(exp_off));
    if (exp_off) chk(intr_vector == hv, "R4", {tag, " offer vector"}, int'(intr_vector), int'(hv));
    afire = ack && exp_off;
    ih = highest(misr);
    efire = eoi && (ih >= 0);
    exp_acc = av && e && (!mpend[avec] || (afire && hv == avec));
    chk(acc_ok == exp_acc, "R2", {tag, " accept result"}, int'(acc_ok), int'(exp_acc));
    chk(ppr_out == m_ppr, "R5", {tag, " priority"}, int'(ppr_out), int'(m_ppr));
    chk(eoi_valid == m_ev, "R7", {tag, " retire pulse"}, int'(eoi_valid), int'(m_ev));
    if (m_ev) begin
      chk(eoi_vector == m_evec, "R7", {tag, " retire vector"}, int'(eoi_vector), int'(m_evec));
      chk(eoi_level == m_elvl, "R7", {tag, " retire trigger"}, int'(eoi_level), int'(m_elvl));
    end
    m_ppr = pp;
    m_ev  = efire;
    if (efire) begin
      m_evec = 8'(ih);
      m_elvl = mtmr[ih];
    end
    if (afire) begin mpend[hv] = 1'b0; misr[hv] = 1'b1; end
    if (efire) begin misr[ih] = 1'b0; mtmr[ih] = 1'b0; end
    if (exp_acc) begin mpend[avec] = 1'b1; mtmr[avec] = alvl; end
    if (tw) mtpr = td;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    step(0, 8'h00, 0, 0, 0, 0, 8'h00, 1, tag);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: clean state after reset
    chk(intr_valid == 1'b0, "R1", "offer after reset", int'(intr_valid), 0);
    chk(eoi_valid == 1'b0, "R1", "retire after reset", int'(eoi_valid), 0);
    chk(ppr_out == 8'h00, "R1", "priority after reset", int'(ppr_out), 0);
    idle("R1");
    // R3: disabled accept dropped, and stays absent after enabling
    step(1, 8'h50, 0, 0, 0, 0, 8'h00, 0, "R3");
    idle("R3");
    chk(intr_valid == 1'b0, "R3", "nothing waiting after disabled accept", int'(intr_valid), 0);
    // R2: accepts and a duplicate
    step(1, 8'h50, 0, 0, 0, 0, 8'h00, 1, "R2");
    step(1, 8'h81, 1, 0, 0, 0, 8'h00, 1, "R2");
    step(1, 8'h85, 0, 0, 0, 0, 8'h00, 1, "R2");
    step(1, 8'h81, 0, 0, 0, 0, 8'h00, 1, "R2 duplicate");
    idle("R4");
    // R6: acknowledge 0x85, then 0x81 withheld (same class)
    step(0, 8'h00, 0, 1, 0, 0, 8'h00, 1, "R6");
    idle("R6");
    chk(intr_valid == 1'b0, "R6", "same class withheld", int'(intr_valid), 0);
    idle("R5");
    chk(ppr_out == 8'h80, "R5", "priority from service class", int'(ppr_out), 8'h80);
    // R7: retire edge 0x85, then take and retire level 0x81
    step(0, 8'h00, 0, 0, 1, 0, 8'h00, 1, "R7");
    idle("R7");
    step(0, 8'h00, 0, 1, 0, 0, 8'h00, 1, "R7");
    step(0, 8'h00, 0, 0, 1, 0, 8'h00, 1, "R7");
    idle("R7");
    chk(eoi_level == 1'b1, "R7", "level retirement", int'(eoi_level), 1);
    // R8: retirement with nothing in service
    step(0, 8'h00, 0, 0, 1, 0, 8'h00, 1, "R8");
    idle("R8");
    chk(eoi_valid == 1'b0, "R8", "no pulse on empty retire", int'(eoi_valid), 0);
    // R10: acknowledge without offer
    step(0, 8'h00, 0, 0, 0, 1, 8'h50, 1, "R10");
    step(0, 8'h00, 0, 1, 0, 0, 8'h00, 1, "R10");
    step(0, 8'h00, 0, 0, 0, 1, 8'h00, 1, "R10");
    idle("R10");
    chk(intr_valid && intr_vector == 8'h50, "R10", "vector kept", int'(intr_vector), 8'h50);
    // R3: disabled withholds offer
    step(0, 8'h00, 0, 0, 0, 0, 8'h00, 0, "R3");
    // R9: accept and acknowledge of same vector in one cycle
    step(1, 8'h90, 0, 0, 0, 0, 8'h00, 1, "R9");
    step(1, 8'h90, 1, 1, 0, 0, 8'h00, 1, "R9");
    step(0, 8'h00, 0, 0, 1, 0, 8'h00, 1, "R9");
    idle("R9");
    chk(intr_valid && intr_vector == 8'h90, "R9", "re-offer", int'(intr_vector), 8'h90);
    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 2) != 0, 8'($urandom_range(16, 255)),
           1'($urandom_range(0, 1)), $urandom_range(0, 1) == 1,
           $urandom_range(0, 3) == 0, $urandom_range(0, 19) == 0,
           8'($urandom_range(0, 255)), $urandom_range(0, 19) != 0, "rand");
    end
    repeat (3) idle("tail");
    finish_run();
  end
endmodule